// File: doc/BRIEF.md
# Grouped-direction digital I/O port

An eight-line bidirectional digital I/O port controlled through one 16-bit register. The low byte of the register holds the value to drive on the lines. Two direction bits in the same register each turn one group of four lines into outputs or inputs. The direction is set per group, not per line.

A register read returns the levels actually present on all eight pads, whether the pad is being driven or sensed. The bits for a driven line therefore show what the pad really carries, not just what was written. Pad levels cross into the clock domain through a two-flop synchroniser before they reach the read data.

The block connects to a simple register write strobe with write data and a read data bus that is always valid. On the pad side, each line has an output value, an output enable and an input level.

Top module: `gio_port`

## Requirements
- R1: While reset is held and right after it, both groups are inputs (all output enables low), the output data latch is 0, and the read data is 0.
- R2: A write updates the output latch from write bits 7:0, and `pin_out` carries the new value one clock after the write. `pin_out` bit n drives line n.
- R3: Register bit 10 sets the direction of lines 0 to 3. A 1 makes them outputs and raises `pin_oe[3:0]` one clock after the write. A 0 makes them inputs.
- R4: Register bit 11 sets the direction of lines 4 to 7 in the same way, through `pin_oe[7:4]`.
- R5: Read bits 7:0 equal `pin_in` as sampled on the rising edge two edges earlier. This holds for both input lines and driven lines.
- R6: Read bits 11:10 return the two direction bits. Read bits 15:12 and 9:8 always read 0, and writes to them have no effect.
- R7: When no write is strobed, the output latch and the direction bits keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control/data register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data: pad levels in 7:0, direction in 11:10 |
| pin_out | output | 8 | Output value per line |
| pin_oe | output | 8 | Output enable per line, high drives the pad |
| pin_in | input | 8 | Sensed pad level per line |

## Verification
The assertions assume that `pin_in` is stable around the rising clock edge. They also assume that a driven pad reads back its driven value, so read data has a defined level to compare against. The bench meets both assumptions. It changes every input only at the falling edge. It models each pad as the driven value when enabled and otherwise as a random external level. Random writes cover all sixteen bits, including the unused ones. Writes are mixed with idle cycles, so the hold behaviour is exercised between updates.

// File: rtl/gio_port.sv
module gio_port #(
  parameter int LINES   = 8,
  parameter int GRP_W   = 4,
  parameter int REG_W   = 16,
  parameter int DIR_LSB = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [LINES-1:0] pin_out,
  output logic [LINES-1:0] pin_oe,
  input  logic [LINES-1:0] pin_in
);
  localparam int NGRP = LINES / GRP_W;

  logic [LINES-1:0] out_q;
  logic [NGRP-1:0]  dir_q;
  logic [LINES-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (reg_wr) begin
      out_q <= reg_wdata[LINES-1:0];
      dir_q <= reg_wdata[DIR_LSB +: NGRP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      assign pin_oe[g*GRP_W +: GRP_W] = {GRP_W{dir_q[g]}};
    end
  endgenerate

  assign pin_out = out_q;

  always_comb begin
    reg_rdata = '0;
    reg_rdata[LINES-1:0] = sync_q;
    reg_rdata[DIR_LSB +: NGRP] = dir_q;
  end
endmodule

// File: rtl/gio_port_chk.sv
module gio_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic [7:0]  pin_out,
  input logic [7:0]  pin_oe,
  input logic [7:0]  pin_in
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (pin_oe == 8'h00 && pin_out == 8'h00);
    end
  end

  p_wr_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> pin_out == $past(reg_wdata[7:0]));

  p_dir_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> pin_oe[3:0] == {4{$past(reg_wdata[10])}});

  p_dir_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> pin_oe[7:4] == {4{$past(reg_wdata[11])}});

  p_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> reg_rdata[7:0] == $past(pin_in, 2));

  p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15:12] == 4'h0 && reg_rdata[9:8] == 2'b00);

  p_dir_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[11:10] == {pin_oe[4], pin_oe[0]});

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(pin_out) && $stable(pin_oe));
endmodule

bind gio_port gio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
);

// File: tb/tb_gio_port.sv
module tb_gio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  pin_out, pin_oe, pin_in, ext;

  int compared = 0;
  int mismatched = 0;
  int unsigned seed = 32'd2718;

  logic [7:0] m_lat, m_s1, m_s2;
  logic [1:0] m_dir;

  always #2 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gio_port dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat <= '0; m_dir <= '0; m_s1 <= '0; m_s2 <= '0;
    end else begin
      if (reg_wr) begin
        m_lat <= reg_wdata[7:0];
        m_dir <= reg_wdata[11:10];
      end
      m_s1 <= pin_in;
      m_s2 <= m_s1;
    end
  end

  function automatic logic [7:0] exp_oe(input logic [1:0] d);
    return {{4{d[1]}}, {4{d[0]}}};
  endfunction

  function automatic logic [15:0] exp_rd(input logic [1:0] d, input logic [7:0] lv);
    return {4'h0, d, 2'b00, lv};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R3/R4 oe", {8'h00, pin_oe}, {8'h00, exp_oe(m_dir)});
    chk("R2/R7 out", {8'h00, pin_out}, {8'h00, m_lat});
    chk("R5/R6 rdata", reg_rdata, exp_rd(m_dir, m_s2));
  endtask

  task automatic wr(input logic [15:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    ext = 8'hA5;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 oe", {8'h00, pin_oe}, 16'h0000);
    chk("R1 out", {8'h00, pin_out}, 16'h0000);
    chk("R1 rdata", reg_rdata, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R5: external level on input lines after two edges
    chk("R5 inputs", reg_rdata, 16'h00A5);
    // R6: unused bits ignored, direction readback
    wr(16'hFFFF);
    chk("R6 readback", {reg_rdata[15:8], 8'h00}, 16'h0C00);
    chk("R3 oe lo", {12'h0, pin_oe[3:0]}, 16'h000F);
    chk("R4 oe hi", {12'h0, pin_oe[7:4]}, 16'h000F);
    @(negedge clk); @(negedge clk);
    // R5: driven lines read back driven value
    chk("R5 driven", reg_rdata, 16'h0CFF);
    // R3 only group 0 output
    ext = 8'h30;
    wr(16'h0405);
    chk("R3 mix", {8'h00, pin_oe}, 16'h000F);
    @(negedge clk); @(negedge clk);
    chk("R5 mix", reg_rdata, 16'h0435);
    // R4 only group 1 output
    wr(16'h0890);
    @(negedge clk); @(negedge clk);
    chk("R4 mix", reg_rdata, 16'h0890);
    // R7: idle cycles hold
    repeat (5) @(negedge clk);
    chk("R7 hold", {8'h00, pin_out}, 16'h0090);
    // random phase
    for (int i = 0; i < 2000; i++) begin
      check_all();
      reg_wr = ($urandom(seed) % 3) == 0;
      seed = seed + 1;
      reg_wdata = 16'($urandom(seed));
      seed = seed + 7;
      ext = 8'($urandom(seed));
      seed = seed + 13;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    // R1: reset mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rerst", {pin_oe, pin_out}, 16'h0000);
    chk("R1 rerst rd", reg_rdata, 16'h0000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule